// File: doc/BRIEF.md
# Two-Wire Keyboard/Mouse Bus Frame Receiver (Host Side)

This block sits on the host side of an open-collector two-wire keyboard/mouse bus and receives the frames a device sends. It brings the bus clock and bus data lines into the system clock domain through two-flop synchronizers. It then drops pulses on them that are shorter than a programmable number of system clocks. Each falling edge of the filtered bus clock shifts one filtered data bit into an 11-bit frame.

Once a frame is complete, its framing is checked: a zero start bit, odd parity over the byte and its parity bit, and a one stop bit. A good frame updates the byte output and raises a one-cycle valid strobe. A bad frame raises a one-cycle error pulse and leaves the byte output as it was. A partial frame is thrown away when the host holds the bus inhibited, or when the bus clock stops toggling in the middle of a frame. The device is expected to send that frame again later.

Top module: `ps2_host_rx`

## Requirements
- R1: After a synchronous reset, `rx_data_o` is 0x00 and both `rx_valid_o` and `rx_err_o` are low.
- R2: A frame is 11 bits, each taken from the data line on a falling edge of the bus clock, in this order: start bit, eight data bits with the least significant bit first, parity bit, stop bit. A frame with correct framing puts its byte on `rx_data_o` and raises `rx_valid_o` for exactly one system clock.
- R3: The parity check is odd: the eight data bits plus the parity bit must hold an odd count of ones. Otherwise `rx_err_o` pulses for one cycle, `rx_valid_o` stays low and `rx_data_o` keeps its previous value.
- R4: A start bit of 1 causes an error pulse in place of the valid strobe, and `rx_data_o` is left unchanged.
- R5: A stop bit of 0 causes an error pulse in place of the valid strobe, and `rx_data_o` is left unchanged.
- R6: A level on the bus clock line lasting fewer than `FILTER_LEN` system clocks is ignored. Such a glitch inside a frame or on an idle bus neither adds a bit nor produces a pulse.
- R7: While `inhibit_i` is high, the partial frame is discarded and falling edges are ignored. The next complete frame is received correctly.
- R8: If a frame has started and no falling edge of the bus clock arrives for `TIMEOUT_CYC` system clocks, the partial frame is discarded and no pulse is produced. The next complete frame is received correctly.
- R9: `rx_valid_o` and `rx_err_o` are never high together, and each is high for at most one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_clk_i | input | 1 | Bus clock line level (asynchronous) |
| ps_dat_i | input | 1 | Bus data line level (asynchronous) |
| inhibit_i | input | 1 | High while the host holds the bus inhibited |
| rx_data_o | output | 8 | Last correctly received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a good frame |
| rx_err_o | output | 1 | One-cycle pulse for a frame with bad start, parity or stop |

## Verification
The assertions take for granted that the data line is steady around each falling edge of the bus clock. They also take for granted that the bus-clock phases are much longer than `FILTER_LEN`, so each filtered edge stands for one real bus edge. The stimulus meets this by changing the data line only at the middle of the clock-high phase, with both phases many times the filter length. Short clock glitches are placed only inside a high phase or on an idle bus, never where they could meet a data change. The bench shortens `TIMEOUT_CYC` so that stalled frames resolve quickly. Every gap between frames is either well under that limit or well over it, never near it.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

    localparam int FRAME_BITS = 11;
    localparam int BYTE_BITS  = 8;

    typedef struct packed {
        logic                 stop;
        logic                 parity;
        logic [BYTE_BITS-1:0] data;
        logic                 start;
    } ps2_frame_t;

    typedef enum logic [1:0] {
        FR_GOOD       = 2'd0,
        FR_BAD_START  = 2'd1,
        FR_BAD_PARITY = 2'd2,
        FR_BAD_STOP   = 2'd3
    } frame_status_e;

    function automatic frame_status_e classify(input ps2_frame_t f);
        frame_status_e s;
        if (f.start)
            s = FR_BAD_START;
        else if (!(^{f.parity, f.data}))
            s = FR_BAD_PARITY;
        else if (!f.stop)
            s = FR_BAD_STOP;
        else
            s = FR_GOOD;
        return s;
    endfunction

endpackage

// File: rtl/ps2rx_line_filter.sv
module ps2rx_line_filter #(
    parameter int FILTER_LEN = 8,
    parameter bit IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level_o
);
    localparam int CW = $clog2(FILTER_LEN + 1);

    logic          sync_a, sync_b;
    logic          level_q;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a  <= IDLE_LEVEL;
            sync_b  <= IDLE_LEVEL;
            level_q <= IDLE_LEVEL;
            run_cnt <= '0;
        end else begin
            sync_a <= line_i;
            sync_b <= sync_a;
            if (sync_b == level_q) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(FILTER_LEN - 1)) begin
                level_q <= sync_b;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign level_o = level_q;

    AST_FILTER_STABLE: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> ($past(sync_b) == level_q && $past(sync_b, 2) == level_q)); // R6

endmodule

// File: rtl/ps2rx_frame_shift.sv
module ps2rx_frame_shift
    import ps2rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_clk_i,
    input  logic       bus_dat_i,
    input  logic       inhibit_i,
    output logic       done_o,
    output ps2_frame_t frame_o
);
    localparam int BW = $clog2(FRAME_BITS + 1);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic                  clk_d;
    logic                  fall;
    logic [BW-1:0]         bit_cnt;
    logic [TW-1:0]         idle_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  done_q;

    assign fall = clk_d & ~bus_clk_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d    <= 1'b1;
            bit_cnt  <= '0;
            idle_cnt <= '0;
            shreg    <= '0;
            done_q   <= 1'b0;
        end else begin
            clk_d  <= bus_clk_i;
            done_q <= 1'b0;
            if (inhibit_i) begin
                bit_cnt  <= '0;
                idle_cnt <= '0;
            end else if (fall) begin
                shreg    <= {bus_dat_i, shreg[FRAME_BITS-1:1]};
                idle_cnt <= '0;
                if (bit_cnt == BW'(FRAME_BITS - 1)) begin
                    bit_cnt <= '0;
                    done_q  <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (bit_cnt != '0) begin
                if (idle_cnt == TW'(TIMEOUT_CYC - 1)) begin
                    bit_cnt  <= '0;
                    idle_cnt <= '0;
                end else begin
                    idle_cnt <= idle_cnt + 1'b1;
                end
            end
        end
    end

    assign done_o  = done_q;
    assign frame_o = ps2_frame_t'(shreg);

    AST_BITCNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        bit_cnt < BW'(FRAME_BITS)); // R2
    AST_INHIBIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        inhibit_i |=> (bit_cnt == '0 && !done_q)); // R7
    AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (rst)
        idle_cnt < TW'(TIMEOUT_CYC)); // R8
    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt != '0 && !fall && !inhibit_i && idle_cnt == TW'(TIMEOUT_CYC - 1)) |=> (bit_cnt == '0)); // R8

endmodule

// File: rtl/ps2rx_frame_check.sv
module ps2rx_frame_check
    import ps2rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done_i,
    input  ps2_frame_t           frame_i,
    output logic [BYTE_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 err_o
);
    frame_status_e        status;
    logic [BYTE_BITS-1:0] data_q;
    logic                 valid_q, err_q;

    assign status = classify(frame_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            if (done_i) begin
                if (status == FR_GOOD) begin
                    data_q  <= frame_i.data;
                    valid_q <= 1'b1;
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    assign data_o  = data_q;
    assign valid_o = valid_q;
    assign err_o   = err_q;

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(valid_q && err_q)); // R9
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q); // R9
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        err_q |=> !err_q); // R9
    AST_ERR_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $stable(data_q)); // R3
    AST_PULSE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (valid_q || err_q) |-> $past(done_i)); // R2

endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx #(
    parameter int FILTER_LEN  = 8,
    parameter int TIMEOUT_CYC = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps_clk_i,
    input  logic       ps_dat_i,
    input  logic       inhibit_i,
    output logic [7:0] rx_data_o,
    output logic       rx_valid_o,
    output logic       rx_err_o
);
    import ps2rx_pkg::*;

    logic       clk_lvl, dat_lvl;
    logic       frame_done;
    ps2_frame_t frame;

    ps2rx_line_filter #(.FILTER_LEN(FILTER_LEN), .IDLE_LEVEL(1'b1)) u_clk_filt (
        .clk(clk), .rst(rst), .line_i(ps_clk_i), .level_o(clk_lvl)
    );

    ps2rx_line_filter #(.FILTER_LEN(FILTER_LEN), .IDLE_LEVEL(1'b1)) u_dat_filt (
        .clk(clk), .rst(rst), .line_i(ps_dat_i), .level_o(dat_lvl)
    );

    ps2rx_frame_shift #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_shift (
        .clk(clk), .rst(rst),
        .bus_clk_i(clk_lvl), .bus_dat_i(dat_lvl), .inhibit_i(inhibit_i),
        .done_o(frame_done), .frame_o(frame)
    );

    ps2rx_frame_check u_check (
        .clk(clk), .rst(rst),
        .done_i(frame_done), .frame_i(frame),
        .data_o(rx_data_o), .valid_o(rx_valid_o), .err_o(rx_err_o)
    );

endmodule

// File: tb/test_ps2_host_rx.sv
module test_ps2_host_rx;
    localparam int FLEN = 8;
    localparam int TOUT = 400;
    localparam int HALF = 60;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ps_clk = 1'b1;
    logic       ps_dat = 1'b1;
    logic       inhibit = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_err;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    int ecount = 0;
    int cycles = 0;
    logic [7:0] model_data = 8'h00;

    always #10 clk = ~clk;

    ps2_host_rx #(.FILTER_LEN(FLEN), .TIMEOUT_CYC(TOUT)) i_ps2_host_rx (
        .clk(clk), .rst(rst), .ps_clk_i(ps_clk), .ps_dat_i(ps_dat),
        .inhibit_i(inhibit), .rx_data_o(rx_data),
        .rx_valid_o(rx_valid), .rx_err_o(rx_err)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rx_valid) vcount <= vcount + 1;
        if (rx_err)   ecount <= ecount + 1;
    end

    always @(negedge clk) begin
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one bus bit: data set mid-high, then a full low phase
    task automatic send_bit(input logic b, input bit glitch);
        wait_cyc(HALF / 2);
        ps_dat = b;
        if (glitch) begin
            wait_cyc(4);
            ps_clk = 1'b0;
            wait_cyc(FLEN / 2);
            ps_clk = 1'b1;
            wait_cyc(HALF / 2 - 4 - FLEN / 2);
        end else begin
            wait_cyc(HALF / 2);
        end
        ps_clk = 1'b0;
        wait_cyc(HALF);
        ps_clk = 1'b1;
    endtask

    // kind: 0 good, 1 parity flip, 2 start bad, 3 stop bad
    task automatic send_frame(input logic [7:0] b, input int kind, input int nbits, input bit glitch);
        logic [10:0] f;
        f = {(kind == 3) ? 1'b0 : 1'b1,
             odd_par(b) ^ (kind == 1),
             b,
             (kind == 2) ? 1'b1 : 1'b0};
        for (int i = 0; i < nbits; i++)
            send_bit(f[i], glitch && (i == 4));
        wait_cyc(HALF / 2);
        ps_dat = 1'b1;
    endtask

    task automatic frame_and_check(input string req, input logic [7:0] b, input int kind, input bit glitch);
        int v0, e0;
        v0 = vcount; e0 = ecount;
        send_frame(b, kind, 11, glitch);
        wait_cyc(40);
        if (kind == 0) model_data = b;
        check(req, vcount - v0, (kind == 0) ? 1 : 0);
        check(req, ecount - e0, (kind == 0) ? 0 : 1);
        check(req, int'(rx_data), int'(model_data));
    endtask

    initial begin
        int v0, e0;
        void'($urandom(32'd20240611));
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        // R1 reset state
        check("R1 data", int'(rx_data), 0);
        check("R1 valid", int'(rx_valid), 0);
        check("R1 err", int'(rx_err), 0);

        // R2 directed patterns
        frame_and_check("R2 0x15", 8'h15, 0, 1'b0);
        frame_and_check("R2 0x00", 8'h00, 0, 1'b0);
        frame_and_check("R2 0xFF", 8'hFF, 0, 1'b0);
        frame_and_check("R2 0x80", 8'h80, 0, 1'b0);
        // R3 R4 R5 error frames leave data alone
        frame_and_check("R3 parity", 8'h5A, 1, 1'b0);
        frame_and_check("R4 start", 8'hC3, 2, 1'b0);
        frame_and_check("R5 stop", 8'h3C, 3, 1'b0);
        // R6 glitch inside a frame and on idle bus
        frame_and_check("R6 glitch frame", 8'hA7, 0, 1'b1);
        v0 = vcount; e0 = ecount;
        for (int g = 0; g < 12; g++) begin
            ps_clk = 1'b0; wait_cyc(FLEN - 3);
            ps_clk = 1'b1; wait_cyc(20);
        end
        frame_and_check("R6 after idle glitches", 8'h6E, 0, 1'b0);

        // R7 inhibit mid-frame
        v0 = vcount; e0 = ecount;
        send_frame(8'h99, 0, 4, 1'b0);
        inhibit = 1'b1;
        wait_cyc(5);
        ps_clk = 1'b0;
        wait_cyc(50);
        ps_clk = 1'b1;
        wait_cyc(20);
        inhibit = 1'b0;
        wait_cyc(20);
        check("R7 no pulse", (vcount - v0) + (ecount - e0), 0);
        frame_and_check("R7 next frame", 8'h4D, 0, 1'b0);

        // R8 timeout mid-frame
        v0 = vcount; e0 = ecount;
        send_frame(8'hE1, 0, 5, 1'b0);
        wait_cyc(TOUT + 100);
        check("R8 no pulse", (vcount - v0) + (ecount - e0), 0);
        frame_and_check("R8 next frame", 8'h2B, 0, 1'b0);

        // R2 R3 R4 R5 R9 random mix
        for (int n = 0; n < 30; n++) begin
            logic [7:0] b;
            int r, kind;
            b = 8'($urandom());
            r = int'($urandom() % 8);
            kind = (r < 4) ? 0 : r - 4;
            if (kind == 0) frame_and_check("R2 random", b, 0, 1'b0);
            else if (kind == 1) frame_and_check("R3 random", b, 1, 1'b0);
            else if (kind == 2) frame_and_check("R4 random", b, 2, 1'b0);
            else frame_and_check("R5 random", b, 3, 1'b0);
        end
        // R9 pulses each counted once per frame above; single-cycle width
        check("R9 idle valid", int'(rx_valid), 0);
        check("R9 idle err", int'(rx_err), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule